// File: doc/BRIEF.md
# SPI Master with Register Bank

This block is a single-slave SPI master that a processor runs through five 32-bit registers. Software picks the clock ratio, clock polarity, clock phase and word width in a configuration register. It drives the one chip-select line through a control bit. A write to the transmit register then starts a single full-duplex shift of 8 or 16 bits. When the last bit has moved, the word received from the slave is latched into the receive register and a completion cause is raised. Software clears that cause by writing the cause register before it starts the next word.

The register port is a request stream. A request is accepted on any cycle where `req_valid` and `req_ready` are both high. `req_ready` is held high, so the block never applies back-pressure. A read produces exactly one response beat on the following cycle, and that response cannot be stalled, so the requester must be able to take it. The serial pins are plain, with no handshake. The serial clock is produced from the system clock by an even division ratio that is derived from a 5-bit prescale code.

Top module: `spim_top`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sclk` is 0. The configuration register reads 0x0000001F. The control, cause and receive registers read 0.
- R2: Writing the control register (byte offset 0x00) copies data bit 0 to the chip-select state, and `spi_cs_n` is the inverse of that bit. Reading the control register returns the chip-select state in bit 0 and a busy flag in bit 1. The busy flag is 1 while a word is shifting.
- R3: `req_ready` is always 1. A read accepted in one cycle is answered in the next cycle with `rsp_valid` high. Byte offsets: 0x00 control, 0x04 configuration, 0x08 transmit, 0x0C receive, 0x10 cause. Configuration fields: bits [4:0] prescale code, bit 5 word width (1 = 16 bits), bit 11 clock polarity, bit 12 clock phase.
- R4: A prescale code c in the range 0x12 to 0x1F gives a serial clock period of 2*(c-16) system clocks. Every code below 0x12 gives a period of 4 system clocks.
- R5: Writing the transmit register while idle starts one transfer, sent MSB first. In 8-bit mode, data bits [7:0] are sent. In 16-bit mode, data bits [15:0] are sent.
- R6: With phase 0, the first bit is on `spi_mosi` before the first clock edge, `spi_miso` is sampled on each leading edge, and `spi_mosi` changes on trailing edges. With phase 1, `spi_mosi` changes on each leading edge and `spi_miso` is sampled on each trailing edge.
- R7: A transfer makes exactly 2 clock edges per bit. Whenever no transfer is running, `spi_sclk` sits at the polarity bit of the configuration register.
- R8: When a word completes, the cause register reads 1 until software writes the cause register, whatever the data written. The write then clears it to 0.
- R9: After completion, the receive register holds the shifted-in word zero-extended: 8 bits in 8-bit mode, 16 bits in 16-bit mode.
- R10: A transmit register write made while a transfer is running is ignored. The word on the line stays unchanged.
- R11: A configuration write made while a transfer is running does not change that transfer's width or clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response beat |
| rsp_rdata | output | 32 | Read response data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The hardest cases to reach from the ports are the writes that arrive while a word is in flight: a second transmit write and a configuration change. These must leave the running transfer untouched. To hit that window, the bench starts a transfer at the slowest prescale code, which leaves 15 system clocks before the first serial edge. In that window it issues a second transmit write with inverted data and a configuration write that flips the width and shortens the ratio. It then checks that the bits on the line, the edge spacing and the received word still follow the original settings. A bench-side slave model drives `spi_miso` and captures `spi_mosi` on the edges that each phase setting calls for.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int CODE_W        = 5;
  localparam int MIN_HALF      = 2;
  localparam int CFG_CPOL_BIT  = 11;
  localparam int CFG_CPHA_BIT  = 12;
  localparam int CFG_WIDE_BIT  = 5;
  localparam int CTRL_CS_BIT   = 0;
  localparam int CTRL_BUSY_BIT = 1;
  localparam int OFS_CTRL      = 'h00;
  localparam int OFS_CFG       = 'h04;
  localparam int OFS_TX        = 'h08;
  localparam int OFS_RX        = 'h0C;
  localparam int OFS_CAUSE     = 'h10;

  typedef struct packed {
    logic              cpha;
    logic              cpol;
    logic              wide;
    logic [CODE_W-1:0] code;
  } spim_cfg_t;

  localparam spim_cfg_t CFG_RESET = '{cpha: 1'b0, cpol: 1'b0, wide: 1'b0, code: 5'h1F};
endpackage

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs import spim_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int WORD_MAX = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic                busy,
  input  logic                done,
  input  logic [WORD_MAX-1:0] rx_word,
  output spim_cfg_t           cfg,
  output logic                cs_on,
  output logic                tx_start,
  output logic [WORD_MAX-1:0] tx_word,
  output logic                cause
);
  logic                wr_en;
  logic                rd_en;
  logic                cs_q;
  spim_cfg_t           cfg_q;
  logic [WORD_MAX-1:0] tx_q;
  logic [WORD_MAX-1:0] rx_q;
  logic                cause_q;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_rdata_q;
  logic [DATA_W-1:0]   rd_mux;
  logic                unused_hi;

  assign wr_en     = req_valid && req_write;
  assign rd_en     = req_valid && !req_write;
  assign tx_start  = wr_en && (req_addr == ADDR_W'(OFS_TX)) && !busy;
  assign tx_word   = req_wdata[WORD_MAX-1:0];
  assign unused_hi = ^req_wdata[DATA_W-1:WORD_MAX];

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      ADDR_W'(OFS_CTRL): begin
        rd_mux[CTRL_CS_BIT]   = cs_q;
        rd_mux[CTRL_BUSY_BIT] = busy;
      end
      ADDR_W'(OFS_CFG): begin
        rd_mux[CFG_CPHA_BIT] = cfg_q.cpha;
        rd_mux[CFG_CPOL_BIT] = cfg_q.cpol;
        rd_mux[CFG_WIDE_BIT] = cfg_q.wide;
        rd_mux[CODE_W-1:0]   = cfg_q.code;
      end
      ADDR_W'(OFS_TX):    rd_mux[WORD_MAX-1:0] = tx_q;
      ADDR_W'(OFS_RX):    rd_mux[WORD_MAX-1:0] = rx_q;
      ADDR_W'(OFS_CAUSE): rd_mux[0] = cause_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 1'b0;
      cfg_q       <= CFG_RESET;
      tx_q        <= '0;
      rx_q        <= '0;
      cause_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_en;
      if (rd_en) rsp_rdata_q <= rd_mux;
      if (wr_en && req_addr == ADDR_W'(OFS_CTRL)) cs_q <= req_wdata[CTRL_CS_BIT];
      if (wr_en && req_addr == ADDR_W'(OFS_CFG)) begin
        cfg_q <= '{cpha: req_wdata[CFG_CPHA_BIT], cpol: req_wdata[CFG_CPOL_BIT],
                   wide: req_wdata[CFG_WIDE_BIT], code: req_wdata[CODE_W-1:0]};
      end
      if (tx_start) tx_q <= req_wdata[WORD_MAX-1:0];
      if (done) rx_q <= rx_word;
      if (done) cause_q <= 1'b1;
      else if (wr_en && req_addr == ADDR_W'(OFS_CAUSE)) cause_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign cfg       = cfg_q;
  assign cs_on     = cs_q;
  assign cause     = cause_q;
endmodule

// File: rtl/spim_clkdiv.sv
`timescale 1ns/1ps
module spim_clkdiv import spim_pkg::*; #(
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          busy,
  input  logic [CW-1:0] code,
  output logic          tick,
  output logic [CW-2:0] half_q
);
  localparam int            HW       = CW - 1;
  localparam logic [CW-1:0] MIN_CODE = CW'((1 << HW) + MIN_HALF);

  logic [HW-1:0] half_dec;
  logic [HW-1:0] cnt_q;
  logic [HW-1:0] half_r;

  // codes below the smallest legal one fall back to the fastest ratio
  assign half_dec = (code < MIN_CODE) ? HW'(MIN_HALF) : code[HW-1:0];
  assign tick     = busy && (cnt_q == half_r - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_r <= '1;
      cnt_q  <= '0;
    end else if (start && !busy) begin
      half_r <= half_dec;
      cnt_q  <= '0;
    end else if (busy) begin
      cnt_q <= tick ? '0 : cnt_q + HW'(1);
    end else begin
      cnt_q <= '0;
    end
  end

  assign half_q = half_r;
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter #(
  parameter int WORD_MAX = 16,
  parameter int NARROW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_wide,
  input  logic [WORD_MAX-1:0] tx_word,
  input  logic                tick,
  input  logic                miso,
  output logic                busy,
  output logic                done,
  output logic [WORD_MAX-1:0] rx_word,
  output logic                sclk_run,
  output logic                mosi,
  output logic [2:0]          lat_mode
);
  localparam int                MSB       = WORD_MAX - 1;
  localparam int                EDGE_W    = $clog2(2 * WORD_MAX);
  localparam logic [EDGE_W-1:0] LAST_WIDE = EDGE_W'(2 * WORD_MAX - 1);
  localparam logic [EDGE_W-1:0] LAST_NARR = EDGE_W'(2 * NARROW - 1);

  logic                busy_q, done_q, phase_q, mosi_q;
  logic                cpol_q, cpha_q, wide_q;
  logic [EDGE_W-1:0]   edge_q;
  logic [WORD_MAX-1:0] tx_sr, rx_sr, load_w;
  logic                shift_edge, last_edge;

  // the word is left-aligned so the line always takes the top bit
  generate
    if (WORD_MAX > NARROW) begin : g_pad
      always_comb load_w = cfg_wide ? tx_word
                                    : {tx_word[NARROW-1:0], {(WORD_MAX-NARROW){1'b0}}};
      assign rx_word = wide_q ? rx_sr : {{(WORD_MAX-NARROW){1'b0}}, rx_sr[NARROW-1:0]};
    end else begin : g_flat
      always_comb load_w = tx_word;
      assign rx_word = rx_sr;
    end
  endgenerate

  // even edges lead; phase 1 moves data on them, phase 0 on the trailing ones
  assign shift_edge = cpha_q ? !edge_q[0] : edge_q[0];
  assign last_edge  = (edge_q == (wide_q ? LAST_WIDE : LAST_NARR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= 1'b0;
      mosi_q  <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      wide_q  <= 1'b0;
      edge_q  <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        edge_q  <= '0;
        cpol_q  <= cfg_cpol;
        cpha_q  <= cfg_cpha;
        wide_q  <= cfg_wide;
        rx_sr   <= '0;
        if (!cfg_cpha) begin
          mosi_q <= load_w[MSB];
          tx_sr  <= {load_w[MSB-1:0], 1'b0};
        end else begin
          tx_sr  <= load_w;
        end
      end else if (busy_q && tick) begin
        phase_q <= !phase_q;
        edge_q  <= edge_q + EDGE_W'(1);
        if (shift_edge) begin
          mosi_q <= tx_sr[MSB];
          tx_sr  <= {tx_sr[MSB-1:0], 1'b0};
        end else begin
          rx_sr  <= {rx_sr[MSB-1:0], miso};
        end
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign sclk_run = cpol_q ^ phase_q;
  assign mosi     = mosi_q;
  assign lat_mode = {cpol_q, cpha_q, wide_q};
endmodule

// File: rtl/spim_top.sv
`timescale 1ns/1ps
module spim_top import spim_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int WORD_MAX = 16,
  parameter int NARROW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  spim_cfg_t           cfg;
  logic                cs_on, tx_start, busy, done, tick, cause, sclk_run;
  logic [WORD_MAX-1:0] tx_word, rx_word;
  logic [CODE_W-2:0]   half_q;
  logic [2:0]          lat_mode;

  assign req_ready = 1'b1;

  spim_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORD_MAX(WORD_MAX)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .busy(busy), .done(done), .rx_word(rx_word),
    .cfg(cfg), .cs_on(cs_on), .tx_start(tx_start), .tx_word(tx_word), .cause(cause)
  );

  spim_clkdiv #(.CW(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .busy(busy), .code(cfg.code),
    .tick(tick), .half_q(half_q)
  );

  spim_shifter #(.WORD_MAX(WORD_MAX), .NARROW(NARROW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .cfg_cpol(cfg.cpol),
    .cfg_cpha(cfg.cpha), .cfg_wide(cfg.wide), .tx_word(tx_word), .tick(tick),
    .miso(spi_miso), .busy(busy), .done(done), .rx_word(rx_word),
    .sclk_run(sclk_run), .mosi(spi_mosi), .lat_mode(lat_mode)
  );

  assign spi_sclk = busy ? sclk_run : cfg.cpol;
  assign spi_cs_n = !cs_on;
endmodule

// File: rtl/spim_chk.sv
`timescale 1ns/1ps
module spim_chk #(
  parameter int HW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          busy,
  input logic          tx_start,
  input logic          cause,
  input logic [HW-1:0] half_q,
  input logic [2:0]    lat_mode
);
  // R3
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R8
  cause_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> cause);

  // R10
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_start));

  // R4
  half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (half_q >= HW'(2)));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lat_mode) && $stable(half_q)));
endmodule

bind spim_top spim_chk #(.HW(4)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .busy(busy), .tx_start(tx_start), .cause(cause),
  .half_q(half_q), .lat_mode(lat_mode)
);

// File: tb/test_spim_top.sv
`timescale 1ns/1ps
module test_spim_top;
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TX = 5'h08, A_RX = 5'h0C, A_CAUSE = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        spi_miso = 1'b0;
  logic        req_ready, rsp_valid, spi_sclk, spi_mosi, spi_cs_n;
  logic [31:0] rsp_rdata;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  spim_top i_spim_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    chk(spi_cs_n == 1'b1, "R1 cs_n after reset", 32'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R1 sclk after reset", 32'(spi_sclk), 0);
    chk(req_ready == 1'b1, "R3 req_ready", 32'(req_ready), 1);
    bus_rd(A_CFG, d, v);
    chk(d == 32'h1F, "R1 cfg reset value", d, 32'h1F);
    chk(v == 1'b1, "R3 read response valid", 32'(v), 1);
    bus_rd(A_CTRL, d, v);
    chk(d == 0, "R1 ctrl reset value", d, 0);
    bus_rd(A_CAUSE, d, v);
    chk(d == 0, "R1 cause reset value", d, 0);
    bus_rd(A_RX, d, v);
    chk(d == 0, "R1 rx reset value", d, 0);
  endtask

  task automatic t_chipsel();
    logic [31:0] d; logic v;
    bus_wr(A_CTRL, 32'h1);
    chk(spi_cs_n == 1'b0, "R2 cs asserted", 32'(spi_cs_n), 0);
    bus_rd(A_CTRL, d, v);
    chk(d == 32'h1, "R2 ctrl readback", d, 1);
    bus_wr(A_CTRL, 32'h0);
    chk(spi_cs_n == 1'b1, "R2 cs released", 32'(spi_cs_n), 1);
  endtask

  task automatic t_idle_level();
    logic [31:0] d; logic v;
    bus_wr(A_CFG, 32'h0000_1835);
    chk(spi_sclk == 1'b1, "R7 idle sclk follows polarity", 32'(spi_sclk), 1);
    bus_rd(A_CFG, d, v);
    chk(d == 32'h0000_1835, "R3 cfg field readback", d, 32'h1835);
    bus_wr(A_CFG, 32'h0000_001F);
    chk(spi_sclk == 1'b0, "R7 idle sclk back low", 32'(spi_sclk), 0);
  endtask

  task automatic do_xfer(input bit cpol, input bit cpha, input bit wide, input logic [4:0] code,
                         input logic [15:0] txw, input logic [15:0] slv, input bit poke,
                         input string name);
    logic [31:0] d, cfgw, pcfg, exp_rx; logic v;
    logic [15:0] got = '0;
    int nb = wide ? 16 : 8;
    int half = (code < 5'h12) ? 2 : int'(code) - 16;
    int t0 = 0, t1 = 0, tries = 0;
    cfgw = (32'(cpha) << 12) | (32'(cpol) << 11) | (32'(wide) << 5) | 32'(code);
    bus_wr(A_CFG, cfgw);
    bus_wr(A_CTRL, 32'h1);
    bus_wr(A_CAUSE, 32'h0);
    spi_miso = cpha ? 1'b0 : slv[nb-1];
    bus_wr(A_TX, {16'hA5A5, txw});
    if (poke) begin
      bus_wr(A_TX, {16'h0, ~txw});
      pcfg = (cfgw & ~32'h3F) | (32'(!wide) << 5) | 32'h12;
      bus_wr(A_CFG, pcfg);
      bus_rd(A_CTRL, d, v);
      chk(d == 32'h3, {"R2 busy bit during ", name}, d, 3);
    end
    for (int e = 0; e < 2 * nb; e++) begin
      @(spi_sclk);
      if (e == 0) t0 = cyc;
      if (e == 1) t1 = cyc;
      if ((e % 2 == 0) != cpha) got = {got[14:0], spi_mosi};
      if (cpha && (e % 2 == 0)) spi_miso = slv[nb-1-e/2];
      if (!cpha && (e % 2 == 1) && ((e + 1) / 2 < nb)) spi_miso = slv[nb-1-(e+1)/2];
    end
    do begin
      bus_rd(A_CTRL, d, v);
      tries++;
    end while (d[1] && tries < 20);
    spi_miso = 1'b0;
    chk(t1 - t0 == half, {"R4 half period ", name}, 32'(t1 - t0), 32'(half));
    if (poke) begin
      chk(got[7:0] == txw[7:0], {"R10 line data kept ", name}, 32'(got[7:0]), 32'(txw[7:0]));
      chk(t1 - t0 == half, {"R11 ratio kept ", name}, 32'(t1 - t0), 32'(half));
    end else begin
      chk(got == (wide ? txw : {8'h0, txw[7:0]}), {"R5 R6 mosi bits ", name},
          32'(got), 32'(wide ? txw : {8'h0, txw[7:0]}));
    end
    chk(spi_sclk == cpol, {"R7 idle level after ", name}, 32'(spi_sclk), 32'(cpol));
    exp_rx = wide ? {16'h0, slv} : {24'h0, slv[7:0]};
    bus_rd(A_RX, d, v);
    chk(d == exp_rx, {"R9 R6 rx word ", name}, d, exp_rx);
    bus_rd(A_CAUSE, d, v);
    chk(d == 32'h1, {"R8 cause set ", name}, d, 1);
    bus_wr(A_CAUSE, 32'hFFFF_FFFF);
    bus_rd(A_CAUSE, d, v);
    chk(d == 32'h0, {"R8 cause cleared ", name}, d, 0);
    bus_wr(A_CTRL, 32'h0);
  endtask

  task automatic t_modes();
    do_xfer(1'b0, 1'b0, 1'b0, 5'h12, 16'h00A5, 16'h003C, 1'b0, "mode0 8b");
    do_xfer(1'b0, 1'b1, 1'b0, 5'h13, 16'h005A, 16'h00C3, 1'b0, "mode1 8b");
    do_xfer(1'b1, 1'b0, 1'b1, 5'h14, 16'hBEEF, 16'h1234, 1'b0, "mode2 16b");
    do_xfer(1'b1, 1'b1, 1'b1, 5'h12, 16'h8001, 16'hF00F, 1'b0, "mode3 16b");
    do_xfer(1'b1, 1'b1, 1'b0, 5'h1F, 16'h3C81, 16'h007E, 1'b0, "mode3 8b upper ignored R5");
  endtask

  task automatic t_clamp();
    do_xfer(1'b0, 1'b0, 1'b0, 5'h05, 16'h00C6, 16'h0099, 1'b0, "code 0x05 clamp R4");
    do_xfer(1'b0, 1'b1, 1'b1, 5'h11, 16'h4321, 16'h8765, 1'b0, "code 0x11 clamp R4");
  endtask

  task automatic t_ignore();
    do_xfer(1'b0, 1'b0, 1'b0, 5'h1F, 16'h0096, 16'h0069, 1'b1, "busy writes R10 R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chipsel();
    t_idle_level();
    t_modes();
    t_clamp();
    t_ignore();
    summary();
    $finish;
  end
endmodule